// File: doc/BRIEF.md
# Slice Ring Writer

This block turns a continuous stream of 16-bit samples into memory writes. The memory is treated as a ring of equal-size slices. Each slice is filled from its base with a fixed number of samples, and that number may be smaller than the slice stride, so the tail of every slice is left alone. Two write channels take turns. While one channel fills the current slice, the other channel is already armed for the next slice. The hand-over happens on the same clock edge as the final write of the slice, so a sample that arrives in the very next cycle is still captured.

Each time a slice completes, the block advances a head index, which wraps at the slice count. It presents the new value together with a one-cycle strobe, so a downstream reader knows which slice is now being filled. The channel that has just finished is re-armed straight away, two slices ahead of the one it wrote.

Control is split over two state machines. The sequencer has the states `SEQ_HOLD` and `SEQ_STREAM`. It is in `SEQ_HOLD` during reset and takes the transition *open* into `SEQ_STREAM` on the first clock edge after reset. Each channel has the states `CH_ARMED` and `CH_RUN`:
- The transition *launch* (`CH_ARMED` to `CH_RUN`) fires when the partner channel finishes.
- The transition *retire* (`CH_RUN` to `CH_ARMED`) fires on the channel's own last sample. It also reloads the channel's target slice.
- After reset, channel 0 starts in `CH_RUN` aimed at slice 0, and channel 1 starts in `CH_ARMED` aimed at slice 1.

Top module: `slice_ring_writer`

## Requirements
- R1: `s_ready` is 0 while `rst_n` is low. It becomes 1 on the first rising clock edge after reset release and stays 1 until the next reset.
- R2: A sample is accepted on an edge where `s_valid` and `s_ready` are both 1. Each accepted sample produces exactly one write in the following cycle: `mem_we` is 1 and `mem_data` equals that sample.
- R3: Samples are numbered n = 0, 1, 2, … in order of acceptance, counting from reset. Sample n is written to address `slice*STRIDE + offset`, where `slice = (n / DATA_LEN) mod SLICES` and `offset = n mod DATA_LEN`.
- R4: No write ever targets an offset at or above `DATA_LEN` within a slice. The region between `DATA_LEN` and `STRIDE` is never written.
- R5: Slices are filled in ascending order, wrapping from `SLICES-1` back to 0. After every reset, filling starts again at slice 0, offset 0.
- R6: Two channels alternate, and only one of them is writing at any time. The first sample of a new slice is written to its base even when it arrives in the cycle straight after the previous slice's last sample.
- R7: `head_stb` is a one-cycle pulse. It is 1 exactly in the cycle that carries the write of the last sample (offset `DATA_LEN-1`) of a slice.
- R8: After reset, `head` is 0. On each strobe, `head` takes the value (old head + 1) mod `SLICES` in the same cycle. Between strobes it does not change. So `head` always equals the number of completed slices mod `SLICES`.
- R9: A cycle in which no sample was accepted produces no write and no strobe. The address sequence then resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | A sample is offered |
| s_data | input | SAMPLE_W | Sample value |
| s_ready | output | 1 | The block can take a sample |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_data | output | SAMPLE_W | Memory write data |
| head | output | SLICE_W | Index of the slice now being filled |
| head_stb | output | 1 | One-cycle pulse: a slice has completed and `head` was updated |

## Verification
A wrong offset counter shows up as a wrong `mem_addr` on the very next write. A channel that retires early or late shifts the strobe away from offset `DATA_LEN-1` within one slice of traffic. A channel re-armed with the wrong slice stays hidden until its turn comes round, up to two slices later. Its first write then lands on the wrong base, which makes `mem_addr / STRIDE` disagree with `head`. A head tracker that is off by one gives the wrong `head` value on the first strobe, and the bench compares `head` after every cycle, so the error is caught there.

// File: rtl/srw_pkg.sv
package srw_pkg;

    // Per-channel control states
    typedef enum logic [0:0] {
        CH_ARMED = 1'b0,
        CH_RUN   = 1'b1
    } ch_state_t;

    // Input sequencer states
    typedef enum logic [0:0] {
        SEQ_HOLD   = 1'b0,
        SEQ_STREAM = 1'b1
    } seq_state_t;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/srw_channel.sv
module srw_channel
    import srw_pkg::*;
#(
    parameter int SLICES     = 4,
    parameter int STRIDE     = 8,
    parameter int DATA_LEN   = 6,
    parameter int ADDR_W     = 5,
    parameter int SLICE_W    = 2,
    parameter int CNT_W      = 3,
    parameter int INIT_SLICE = 0,
    parameter bit START_RUN  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic               take_i,
    input  logic [SLICE_W-1:0] reload_slice_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               last_o,
    output logic               running_o
);

    localparam logic [CNT_W-1:0] LAST_OFF = CNT_W'(DATA_LEN - 1);
    localparam ch_state_t        RST_ST   = START_RUN ? CH_RUN : CH_ARMED;

    ch_state_t          st_q, st_nx;
    logic [ADDR_W-1:0]  base_q;
    logic [CNT_W-1:0]   off_q;
    logic               at_end;

    function automatic logic [ADDR_W-1:0] slice_base(input logic [SLICE_W-1:0] s);
        return ADDR_W'(s) * ADDR_W'(STRIDE);
    endfunction

    assign at_end = (off_q == LAST_OFF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_nx;
    end

    // transitions: launch and retire
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            CH_ARMED: if (go_i)             st_nx = CH_RUN;
            CH_RUN:   if (take_i && at_end) st_nx = CH_ARMED;
            default:                        st_nx = CH_ARMED;
        endcase
    end

    // target slice and fill position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= slice_base(SLICE_W'(INIT_SLICE));
            off_q  <= '0;
        end else if (st_q == CH_RUN && take_i) begin
            if (at_end) begin
                base_q <= slice_base(reload_slice_i);
                off_q  <= '0;
            end else begin
                off_q  <= off_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        running_o = (st_q == CH_RUN);
        last_o    = running_o && at_end;
        addr_o    = base_q + ADDR_W'(off_q);
    end

endmodule

// File: rtl/srw_head_tracker.sv
module srw_head_tracker #(
    parameter int SLICES  = 4,
    parameter int SLICE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv_i,
    output logic [SLICE_W-1:0] head_o,
    output logic [SLICE_W-1:0] reload_o
);

    localparam logic [SLICE_W-1:0] TOP = SLICE_W'(SLICES - 1);

    logic [SLICE_W-1:0] head_q;

    function automatic logic [SLICE_W-1:0] wrap_inc(input logic [SLICE_W-1:0] h);
        return (h == TOP) ? '0 : h + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     head_q <= '0;
        else if (adv_i) head_q <= wrap_inc(head_q);
    end

    // the retiring channel aims one slice past the new head
    always_comb begin
        head_o   = head_q;
        reload_o = wrap_inc(wrap_inc(head_q));
    end

endmodule

// File: rtl/srw_write_stage.sv
module srw_write_stage #(
    parameter int SAMPLE_W = 16,
    parameter int ADDR_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [SAMPLE_W-1:0] data_i,
    input  logic                done_i,
    output logic                we_o,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [SAMPLE_W-1:0] data_o,
    output logic                stb_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_o   <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
            stb_o  <= 1'b0;
        end else begin
            we_o  <= accept_i;
            stb_o <= done_i;
            if (accept_i) begin
                addr_o <= addr_i;
                data_o <= data_i;
            end
        end
    end

endmodule

// File: rtl/slice_ring_writer.sv
module slice_ring_writer
    import srw_pkg::*;
#(
    parameter int  SAMPLE_W = 16,
    parameter int  SLICES   = 4,
    parameter int  STRIDE   = 8,
    parameter int  DATA_LEN = 6,
    localparam int ADDR_W   = $clog2(SLICES * STRIDE),
    localparam int SLICE_W  = $clog2(SLICES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_data,
    output logic                s_ready,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [SAMPLE_W-1:0] mem_data,
    output logic [SLICE_W-1:0]  head,
    output logic                head_stb
);

    localparam int CNT_W = $clog2(DATA_LEN + 1);

    if (DATA_LEN < 1 || DATA_LEN > STRIDE || SLICES < 2) begin : g_bad_cfg
        $error("slice_ring_writer: need 1 <= DATA_LEN <= STRIDE and SLICES >= 2");
    end

    seq_state_t         seq_q, seq_nx;
    logic               accept;
    logic [NUM_CH-1:0]  ch_running, ch_last, ch_take, ch_done, ch_go;
    logic [ADDR_W-1:0]  ch_addr [NUM_CH];
    logic [ADDR_W-1:0]  addr_sel;
    logic               slice_done;
    logic [SLICE_W-1:0] head_cur, reload_slice;

    // sequencer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_HOLD;
        else        seq_q <= seq_nx;
    end

    // sequencer transition: open
    always_comb begin
        seq_nx = seq_q;
        unique case (seq_q)
            SEQ_HOLD:   seq_nx = SEQ_STREAM;
            SEQ_STREAM: seq_nx = SEQ_STREAM;
            default:    seq_nx = SEQ_HOLD;
        endcase
    end

    // sequencer outputs
    always_comb begin
        s_ready = (seq_q == SEQ_STREAM);
        accept  = s_valid && s_ready;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_take[c] = accept && ch_running[c];
        assign ch_done[c] = ch_take[c] && ch_last[c];
        assign ch_go[c]   = ch_done[NUM_CH - 1 - c];

        srw_channel #(
            .SLICES     (SLICES),
            .STRIDE     (STRIDE),
            .DATA_LEN   (DATA_LEN),
            .ADDR_W     (ADDR_W),
            .SLICE_W    (SLICE_W),
            .CNT_W      (CNT_W),
            .INIT_SLICE (c),
            .START_RUN  (c == 0)
        ) u_ch (
            .clk            (clk),
            .rst_n          (rst_n),
            .go_i           (ch_go[c]),
            .take_i         (ch_take[c]),
            .reload_slice_i (reload_slice),
            .addr_o         (ch_addr[c]),
            .last_o         (ch_last[c]),
            .running_o      (ch_running[c])
        );
    end

    // address of whichever channel is writing
    always_comb begin
        addr_sel = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_running[c]) addr_sel = addr_sel | ch_addr[c];
        end
        slice_done = |ch_done;
    end

    srw_head_tracker #(
        .SLICES  (SLICES),
        .SLICE_W (SLICE_W)
    ) u_head (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (slice_done),
        .head_o   (head_cur),
        .reload_o (reload_slice)
    );

    assign head = head_cur;

    srw_write_stage #(
        .SAMPLE_W (SAMPLE_W),
        .ADDR_W   (ADDR_W)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .addr_i   (addr_sel),
        .data_i   (s_data),
        .done_i   (slice_done),
        .we_o     (mem_we),
        .addr_o   (mem_addr),
        .data_o   (mem_data),
        .stb_o    (head_stb)
    );

endmodule

// File: rtl/srw_checker.sv
module srw_checker #(
    parameter int SLICES   = 4,
    parameter int STRIDE   = 8,
    parameter int DATA_LEN = 6,
    parameter int ADDR_W   = 5,
    parameter int SLICE_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s_ready,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [SLICE_W-1:0] head,
    input logic               head_stb,
    input logic [1:0]         run_vec
);

    // R1
    ready_in_reset_chk: assert property (@(posedge clk) !rst_n |-> !s_ready);

    // R1
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> s_ready);

    // R4
    tail_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((int'(mem_addr) % STRIDE) < DATA_LEN));

    // R7
    stb_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_stb |-> (mem_we && ((int'(mem_addr) % STRIDE) == DATA_LEN - 1)));

    if (DATA_LEN > 1) begin : g_pulse
        // R7
        stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            head_stb |=> !head_stb);
    end

    // R8
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_stb |-> (int'(head) == ((int'($past(head)) + 1) % SLICES)));

    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !head_stb |-> $stable(head));

    // R5
    slice_matches_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !head_stb) |-> ((int'(mem_addr) / STRIDE) == int'(head)));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && !$past(head_stb))
            |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R6
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(run_vec) == 1);

endmodule

bind slice_ring_writer srw_checker #(
    .SLICES   (SLICES),
    .STRIDE   (STRIDE),
    .DATA_LEN (DATA_LEN),
    .ADDR_W   (ADDR_W),
    .SLICE_W  (SLICE_W)
) u_srw_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_ready  (s_ready),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .head     (head),
    .head_stb (head_stb),
    .run_vec  (ch_running)
);

// File: tb/slice_ring_writer_bench.sv
module slice_ring_writer_bench;

    localparam int W  = 16;
    localparam int S  = 4;
    localparam int ST = 8;
    localparam int DL = 6;
    localparam int AW = 5;
    localparam int HW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_valid = 1'b0;
    logic [W-1:0]  s_data = '0;
    logic          s_ready;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_data;
    logic [HW-1:0] head;
    logic          head_stb;

    int checks = 0;
    int failures = 0;
    int n_acc = 0;
    bit pend = 1'b0;
    int pend_n = 0;
    logic [W-1:0] pend_data = '0;
    bit prev_wr = 1'b0;

    always #5 clk = ~clk;

    slice_ring_writer #(
        .SAMPLE_W (W),
        .SLICES   (S),
        .STRIDE   (ST),
        .DATA_LEN (DL)
    ) u_slice_ring_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_valid  (s_valid),
        .s_data   (s_data),
        .s_ready  (s_ready),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .head     (head),
        .head_stb (head_stb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // compare outputs against the write expected from the previous edge
    task automatic check_outputs();
        int slc, off;
        chk("R1 ready high after reset", int'(s_ready), 1);
        if (pend) begin
            slc = (pend_n / DL) % S;
            off = pend_n % DL;
            chk("R2 write enable", int'(mem_we), 1);
            chk("R2 write data", int'(mem_data), int'(pend_data));
            chk("R3 address", int'(mem_addr), slc * ST + off);
            chk("R4 offset inside fill", int'((int'(mem_addr) % ST) < DL), 1);
            chk("R5 slice index", int'(mem_addr) / ST, slc);
            if (off == 0 && pend_n > 0 && prev_wr)
                chk("R6 back-to-back slice base", int'(mem_addr), slc * ST);
            chk("R7 strobe on last", int'(head_stb), int'(off == DL - 1));
            chk("R8 head", int'(head),
                (off == DL - 1) ? ((pend_n / DL) + 1) % S : slc);
        end else begin
            chk("R9 no write when idle", int'(mem_we), 0);
            chk("R7 no strobe when idle", int'(head_stb), 0);
            chk("R8 head stable", int'(head), (n_acc / DL) % S);
        end
        prev_wr = pend;
    endtask

    task automatic step(input logic v, input logic [W-1:0] d);
        @(negedge clk);
        check_outputs();
        pend      = v && s_ready;
        pend_n    = n_acc;
        pend_data = d;
        if (pend) n_acc++;
        s_valid = v;
        s_data  = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        s_valid = 1'b1;
        s_data  = 16'hDEAD;
        repeat (3) begin
            @(negedge clk);
            chk("R1 ready low in reset", int'(s_ready), 0);
            chk("R2 no write in reset", int'(mem_we), 0);
            chk("R8 head zero in reset", int'(head), 0);
            chk("R7 no strobe in reset", int'(head_stb), 0);
        end
        s_valid = 1'b0;
        rst_n   = 1'b1;
        n_acc   = 0;
        pend    = 1'b0;
        prev_wr = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        summary();
    end

    initial begin
        do_reset();

        // continuous stream wrapping the ring three times (R3 R5 R6 R7 R8)
        for (int i = 0; i < 3 * S * DL + 3; i++) step(1'b1, 16'(16'hA000 + i * 37));

        // sparse pattern with gaps (R9)
        for (int i = 0; i < 160; i++)
            step(((i % 5) != 2) && ((i % 7) != 0), 16'(16'h5000 + i * 91));

        // one slice per burst followed by idle cycles
        for (int b = 0; b < 2 * S; b++) begin
            for (int k = 0; k < DL; k++) step(1'b1, 16'(b * 256 + k));
            for (int k = 0; k <= (b % 3); k++) step(1'b0, 16'hFFFF);
        end

        // long idle, head must hold (R8)
        for (int i = 0; i < 20; i++) step(1'b0, 16'h0);

        // reset in the middle of a slice, then restart at slice 0 (R5)
        for (int i = 0; i < DL + 2; i++) step(1'b1, 16'(16'h7700 + i));
        step(1'b0, 16'h0);
        do_reset();
        for (int i = 0; i < 2 * DL + 1; i++) step(1'b1, 16'(16'h1200 + i));
        step(1'b0, 16'h0);
        step(1'b0, 16'h0);

        summary();
    end

endmodule